// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block gathers single-cycle event pulses from the receive and transmit paths of an Ethernet MAC into one 32-bit sticky status word. Every event bit has a matching bit in an enable word. Enabled receive events are OR-ed into a receive summary bit in the status word, and enabled transmit events into a transmit summary bit. The receive summary reaches the CPU only when a receive master enable is set. The transmit summary drives its own interrupt line directly.

Software reaches both words over a simple single-cycle register bus. Reads are combinational from the current state. Writes take effect at the next clock edge. Status bits are cleared by writing ones to them. Both interrupt outputs are levels, and each stays high until the bits feeding it are cleared or masked.

Top module: `mac_irq_agg`

## Requirements
- R1: After reset the status word (address 0) and the enable word (address 1) both read 0, and `irq_rx` and `irq_tx` are low.
- R2: An event pulse on an event position (receive positions 1 to 11 and 14, transmit positions 17 to 24) sets that status bit at the next clock edge. The bit then stays set until it is cleared.
- R3: A bus write to address 0 clears every event bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R4: If an event pulse and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status positions 12, 13, 15 and 25 to 31 always read 0, and pulses on those event inputs have no effect.
- R6: Status bit 0 reads 1 exactly when some receive event bit is set together with its matching enable bit.
- R7: Status bit 16 reads 1 exactly when some transmit event bit is set together with its matching enable bit.
- R8: `irq_rx` equals status bit 0 AND enable bit 0 (the receive master enable).
- R9: `irq_tx` equals status bit 16.
- R10: Writing 1 to status bit 0 clears all receive event bits whose enable bits are 1. Writing 1 to status bit 16 does the same for the enabled transmit event bits.
- R11: The enable word holds bit 0 and the event positions. All of its other bits read 0 and ignore writes. Addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one per status position |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 = status, 1 = enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when no read is selected |
| irq_rx | output | 1 | Receive interrupt level |
| irq_tx | output | 1 | Transmit interrupt level |

## Verification
A lost or stuck status flop shows up at the first status read after the event. It also moves an interrupt line in the same cycle, as soon as the matching enable is set. A wrong enable bit can stay hidden until an event lands on that position, so the random stimulus keeps the enable word changing while events arrive. Clear races and summary-bit clears are set up as directed cases, because a wrong priority in those cases only shows one cycle later as a bit that is missing or a bit that survives.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int RX_SUM   = 0;
  localparam int TX_SUM   = 16;
  localparam int RX_LO    = 1;
  localparam int RX_HI    = 11;
  localparam int RX_XTRA  = 14;
  localparam int TX_LO    = 17;
  localparam int TX_HI    = 24;

  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 2'd1;

  typedef logic [DATA_W-1:0] word_t;

  function automatic word_t range_mask(int lo, int hi);
    word_t m;
    m = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  localparam word_t RX_MASK  = range_mask(RX_LO, RX_HI) | range_mask(RX_XTRA, RX_XTRA);
  localparam word_t TX_MASK  = range_mask(TX_LO, TX_HI);
  localparam word_t EVT_MASK = RX_MASK | TX_MASK;
  localparam word_t EN_MASK  = EVT_MASK | range_mask(RX_SUM, RX_SUM);
endpackage

// File: rtl/mac_irq_status_bank.sv
module mac_irq_status_bank
  import mac_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t evt,
  input  word_t clr,
  output word_t stat_q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (EVT_MASK[i]) begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (evt[i]) q <= 1'b1;
        else if (clr[i]) q <= 1'b0;
      end
      assign stat_q[i] = q;
    end else begin : g_rsv
      assign stat_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mac_irq_summary.sv
module mac_irq_summary
  import mac_irq_pkg::*;
(
  input  word_t stat_q,
  input  word_t en_q,
  input  word_t clr_raw,
  output logic  rx_sum,
  output logic  tx_sum,
  output word_t clr,
  output word_t stat_view
);
  word_t live;
  assign live   = stat_q & en_q;
  assign rx_sum = |(live & RX_MASK);
  assign tx_sum = |(live & TX_MASK);

  always_comb begin
    clr = clr_raw & EVT_MASK;
    if (clr_raw[RX_SUM]) clr = clr | (en_q & RX_MASK);
    if (clr_raw[TX_SUM]) clr = clr | (en_q & TX_MASK);
  end

  always_comb begin
    stat_view         = stat_q & EVT_MASK;
    stat_view[RX_SUM] = rx_sum;
    stat_view[TX_SUM] = tx_sum;
  end
endmodule

// File: rtl/mac_irq_regif.sv
module mac_irq_regif
  import mac_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  word_t             bus_wdata,
  input  word_t             stat_view,
  output word_t             bus_rdata,
  output word_t             en_q,
  output word_t             clr_raw
);
  logic wr_stat, wr_en, rd;
  assign wr_stat = bus_sel && bus_we && (bus_addr == A_STAT);
  assign wr_en   = bus_sel && bus_we && (bus_addr == A_EN);
  assign rd      = bus_sel && !bus_we;
  assign clr_raw = wr_stat ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= bus_wdata & EN_MASK;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_STAT:  bus_rdata = stat_view;
        A_EN:    bus_rdata = en_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg
  import mac_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       evt_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_rx,
  output logic              irq_tx
);
  word_t stat_q, en_q, clr_raw, clr, stat_view;
  logic  rx_sum, tx_sum;

  mac_irq_regif u_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_view(stat_view),
    .bus_rdata(bus_rdata), .en_q(en_q), .clr_raw(clr_raw)
  );

  mac_irq_summary u_sum (
    .stat_q(stat_q), .en_q(en_q), .clr_raw(clr_raw),
    .rx_sum(rx_sum), .tx_sum(tx_sum), .clr(clr), .stat_view(stat_view)
  );

  mac_irq_status_bank u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr(clr), .stat_q(stat_q)
  );

  assign irq_rx = rx_sum & en_q[RX_SUM];
  assign irq_tx = tx_sum;
endmodule

// File: rtl/mac_irq_chk.sv
module mac_irq_chk
  import mac_irq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_i,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        irq_rx,
  input logic        irq_tx,
  input logic [31:0] stat_q,
  input logic [31:0] en_q
);
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & EVT_MASK) != '0) |=> ((stat_q & $past(evt_i & EVT_MASK)) == $past(evt_i & EVT_MASK))); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0)); // R2
  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == A_STAT) |-> ((bus_rdata & ~(EVT_MASK | 32'h0001_0001)) == '0)); // R5
  AST_RX_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> en_q[RX_SUM]); // R8
  AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx == (((stat_q & en_q & TX_MASK)) != '0)); // R9
  AST_EN_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_MASK) == '0); // R11
endmodule

bind mac_irq_agg mac_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx),
  .stat_q(stat_q), .en_q(en_q)
);

// File: tb/tb_mac_irq_agg.sv
`timescale 1ns/1ps
module tb_mac_irq_agg;
  localparam logic [31:0] RXM = 32'h0000_4FFE;
  localparam logic [31:0] TXM = 32'h01FE_0000;
  localparam logic [31:0] EVM = RXM | TXM;
  localparam logic [31:0] ENM = EVM | 32'h1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_rx, irq_tx;

  int n_chk = 0, n_fail = 0;
  logic [31:0] s_m = '0, e_m = '0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  mac_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  function automatic logic [31:0] view(logic [31:0] s, logic [31:0] e);
    logic [31:0] v;
    v = s & EVM;
    v[0]  = |(s & e & RXM);
    v[16] = |(s & e & TXM);
    return v;
  endfunction

  function automatic logic [31:0] next_stat(logic [31:0] s, logic [31:0] e, logic [31:0] ev,
                                            logic wr, logic [31:0] wd);
    logic [31:0] c;
    c = '0;
    if (wr) begin
      c = wd & EVM;
      if (wd[0])  c = c | (e & RXM);
      if (wd[16]) c = c | (e & TXM);
    end
    return (s & ~c) | (ev & EVM);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, update model for the edge.
  task automatic cyc(logic [31:0] ev, logic sel, logic we, logic [1:0] a, logic [31:0] wd,
                     string rtag);
    @(negedge clk);
    evt_i = ev; bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    #1;
    if (sel && !we)
      check(rtag, bus_rdata, a == 2'd0 ? view(s_m, e_m) : a == 2'd1 ? e_m : 32'h0);
    check("R8 irq_rx", {31'h0, irq_rx}, {31'h0, view(s_m, e_m)[0] & e_m[0]});
    check("R9 irq_tx", {31'h0, irq_tx}, {31'h0, view(s_m, e_m)[16]});
    s_m = next_stat(s_m, e_m, ev, sel && we && a == 2'd0, wd);
    if (sel && we && a == 2'd1) e_m = wd & ENM;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    cyc('0, 1, 0, 2'd0, '0, "R1 status after reset");
    cyc('0, 1, 0, 2'd1, '0, "R1 enable after reset");
    // R11 enable writable bits only
    cyc('0, 1, 1, 2'd1, 32'hFFFF_FFFF, "");
    cyc('0, 1, 0, 2'd1, '0, "R11 enable readback");
    cyc('0, 1, 1, 2'd3, 32'hFFFF_FFFF, "");
    cyc('0, 1, 0, 2'd3, '0, "R11 unused address");
    // R2 / R5 set all events incl reserved
    cyc(32'hFFFF_FFFF, 0, 0, 2'd0, '0, "");
    cyc('0, 1, 0, 2'd0, '0, "R5 R6 R7 status after all events");
    // R3 write zero leaves, write one clears
    cyc('0, 1, 1, 2'd0, 32'h0000_0000, "");
    cyc('0, 1, 0, 2'd0, '0, "R3 write zero no effect");
    cyc('0, 1, 1, 2'd0, 32'h0000_0006, "");
    cyc('0, 1, 0, 2'd0, '0, "R3 write one clears");
    // R4 collision
    cyc(32'h0000_0010, 1, 1, 2'd0, 32'h0000_0010, "");
    cyc('0, 1, 0, 2'd0, '0, "R4 event beats clear");
    // R10 summary clear with partial enables
    cyc('0, 1, 1, 2'd1, 32'h0002_0101, "");
    cyc('0, 1, 1, 2'd0, 32'h0001_0001, "");
    cyc('0, 1, 0, 2'd0, '0, "R10 summary clears enabled only");
    // R8 master enable off
    cyc('0, 1, 1, 2'd1, 32'h0000_4FFE, "");
    cyc('0, 1, 0, 2'd0, '0, "R8 master off status");
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] ev, wd;
      int op;
      ev = $urandom() & $urandom() & $urandom();
      wd = $urandom() & $urandom();
      op = $urandom_range(0, 7);
      if (op < 2)       cyc(ev, 1, 1, 2'd0, wd, "");
      else if (op == 2) cyc(ev, 1, 1, 2'd1, $urandom(), "");
      else if (op == 3) cyc(ev, 0, 0, 2'd0, '0, "");
      else begin
        logic [1:0] a;
        a = 2'($urandom_range(0, 3));
        cyc(ev, 1, 0, a, '0, a == 2'd0 ? "R2 R6 R7 status read" : "R11 read");
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule